// File: doc/BRIEF.md
# Configurable LFSR Random Generator

This block produces a pseudo-random sequence from a linear feedback shift register. Build-time parameters choose the register width, the structure (shift-input feedback or output-injection feedback), the feedback polarity (XOR or XNOR), and how many register updates are applied in each enabled clock cycle. An optional build-time seed can set the whole register at reset. Without one, reset drives only the single bit that keeps the register out of its stuck state, which keeps reset fanout small.

At run time the register advances while the advance enable is high. A seed-load strobe replaces the state with a supplied seed. A mode input decides whether that seed is written as given or is first passed through the same per-cycle step chain. Maximal-period tap sets are built in for widths 4, 5, 6, 7, 8 and 16.

Top module: `lfsr_rng`

## Requirements
- R1: While the asynchronous reset is low, bit 0 of the state is 1 for XOR feedback and 0 for XNOR feedback, and only bit 0 is reset. When a build-time seed is enabled, every state bit takes the seed value instead.
- R2: When neither the advance enable nor the seed-load strobe is high, the state holds its value.
- R3: The shift-input (Fibonacci) form shifts the state one place towards the MSB. Bit 0 receives the reduction of the state bits selected by the tap mask, which is 0xC for width 4, 0x14 for 5, 0x30 for 6, 0x60 for 7, 0xB8 for 8 and 0xD008 for 16.
- R4: The output-injection (Galois) form shifts the state one place towards the MSB and places the old MSB in bit 0. At every position set in the injection mask, which is the tap mask shifted left by one (truncated to the width), the old MSB is also combined with the shifted bit.
- R5: With XNOR feedback the combinations of R3 and R4 are inverted. Bit 0 of the Galois form still receives the old MSB. The stuck state is all ones for XNOR feedback and all zeros for XOR feedback.
- R6: Each cycle with the enable high and no load applies exactly STEPS single updates.
- R7: A load strobe with mode 0 makes the state equal the seed on the next cycle. A load takes priority over the enable in the same cycle.
- R8: A load strobe with mode 1 makes the state equal the seed after STEPS single updates.
- R9: From any state other than the stuck state, each enabled step changes the state and never enters the stuck state. A single-step register of width N returns to its start after exactly 2^N - 1 steps and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_en_i | input | 1 | Advance the state by STEPS updates |
| seed_ld_i | input | 1 | Load a seed this cycle |
| seed_mode_i | input | 1 | 0: load seed as given; 1: load seed after STEPS updates |
| seed_i | input | W | Seed value |
| state_o | output | W | Current register state |

## Verification
The hardest property to reach from the ports is the full period. The bench must show that the sequence comes back to its start only after 2^N - 1 steps and moves on every one of them. It does this by loading a known seed and holding the enable high for a whole period on an 8-bit XOR instance and a 6-bit XNOR instance at the same time, recording the first return of each. Reset is also hard to check because only bit 0 is defined there. The bench therefore checks only that bit on unseeded instances and all bits on a build-seeded one, then loads seeds before comparing any full sequence against its own step model.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic {
        LFSR_FIB = 1'b0,
        LFSR_GAL = 1'b1
    } lfsr_form_e;

    typedef enum logic {
        FB_XOR  = 1'b0,
        FB_XNOR = 1'b1
    } lfsr_fb_e;

    localparam int unsigned MAX_W = 16;

    // Shift-input tap mask for a maximal-period register of width w.
    function automatic logic [MAX_W-1:0] fib_taps(input int unsigned w);
        logic [MAX_W-1:0] m;
        case (w)
            4:       m = 16'h000C;
            5:       m = 16'h0014;
            6:       m = 16'h0030;
            7:       m = 16'h0060;
            8:       m = 16'h00B8;
            16:      m = 16'hD008;
            default: m = 16'h0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lfsr_step.sv
module lfsr_step
    import lfsr_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter lfsr_form_e  FORM = LFSR_FIB,
    parameter lfsr_fb_e    FB   = FB_XOR
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    localparam logic [MAX_W-1:0] T16  = fib_taps(W);
    localparam logic [W-1:0]     TAPS = T16[W-1:0];
    localparam logic [W-1:0]     INJ  = {TAPS[W-2:0], 1'b1};
    localparam logic             INV  = (FB == FB_XNOR);

    generate
        if (FORM == LFSR_FIB) begin : g_fib
            logic fb_bit;
            assign fb_bit = (^(cur_i & TAPS)) ^ INV;
            assign nxt_o  = {cur_i[W-2:0], fb_bit};
        end else begin : g_gal
            logic msb;
            assign msb      = cur_i[W-1];
            assign nxt_o[0] = msb;
            for (genvar i = 1; i < W; i++) begin : g_bit
                if (INJ[i]) begin : g_inj
                    assign nxt_o[i] = cur_i[i-1] ^ msb ^ INV;
                end else begin : g_pass
                    assign nxt_o[i] = cur_i[i-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lfsr_multi.sv
module lfsr_multi
    import lfsr_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter lfsr_form_e  FORM  = LFSR_FIB,
    parameter lfsr_fb_e    FB    = FB_XOR,
    parameter int unsigned STEPS = 1
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] link [STEPS+1];

    assign link[0] = cur_i;

    generate
        for (genvar s = 0; s < STEPS; s++) begin : g_chain
            lfsr_step #(.W(W), .FORM(FORM), .FB(FB)) step_u (
                .cur_i (link[s]),
                .nxt_o (link[s+1])
            );
        end
    endgenerate

    assign nxt_o = link[STEPS];
endmodule

// File: rtl/lfsr_rng.sv
module lfsr_rng
    import lfsr_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter lfsr_form_e  FORM     = LFSR_FIB,
    parameter lfsr_fb_e    FB       = FB_XOR,
    parameter int unsigned STEPS    = 1,
    parameter bit          HAS_SEED = 1'b0,
    parameter logic [W-1:0] SEED    = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         adv_en_i,
    input  logic         seed_ld_i,
    input  logic         seed_mode_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] state_o
);
    localparam logic         LSB_RST = HAS_SEED ? SEED[0] : (FB == FB_XOR);
    localparam logic [W-1:0] LOCK    = (FB == FB_XOR) ? {W{1'b0}} : {W{1'b1}};
    localparam int unsigned  PERIOD  = (1 << W) - 1;
    localparam bit           MOVES   = (STEPS % PERIOD) != 0;

    logic         lsb_q;
    logic [W-2:0] upper_q;
    logic [W-1:0] stepped;
    logic [W-1:0] seed_adv;
    logic [W-1:0] load_val;
    logic [W-1:0] next_d;

    assign state_o = {upper_q, lsb_q};

    lfsr_multi #(.W(W), .FORM(FORM), .FB(FB), .STEPS(STEPS)) adv_u (
        .cur_i (state_o),
        .nxt_o (stepped)
    );

    lfsr_multi #(.W(W), .FORM(FORM), .FB(FB), .STEPS(STEPS)) seed_u (
        .cur_i (seed_i),
        .nxt_o (seed_adv)
    );

    always_comb begin
        load_val = seed_mode_i ? seed_adv : seed_i;
        if (seed_ld_i) begin
            next_d = load_val;
        end else if (adv_en_i) begin
            next_d = stepped;
        end else begin
            next_d = state_o;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lsb_q <= LSB_RST;
        end else begin
            lsb_q <= next_d[0];
        end
    end

    generate
        if (HAS_SEED) begin : g_upper_rst
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    upper_q <= SEED[W-1:1];
                end else begin
                    upper_q <= next_d[W-1:1];
                end
            end
        end else begin : g_upper_free
            always_ff @(posedge clk_i) begin
                upper_q <= next_d[W-1:1];
            end
        end
    endgenerate

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_en_i && !seed_ld_i) |=> $stable(state_o));

    assert_load_direct_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seed_ld_i && !seed_mode_i) |=> (state_o == $past(seed_i)));

    assert_step_moves_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (MOVES && adv_en_i && !seed_ld_i && state_o != LOCK) |=> (state_o != $past(state_o)));

    assert_no_lockup_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_en_i && !seed_ld_i && state_o != LOCK) |=> (state_o != LOCK));
endmodule

// File: tb/lfsr_rng_tb.sv
module lfsr_rng_tb_top;
    import lfsr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        en = 1'b0;
    logic        ld = 1'b0;
    logic        md = 1'b0;
    logic [15:0] seed = 16'h0;
    logic [7:0]  q_a;
    logic [3:0]  q_b;
    logic [4:0]  q_c;
    logic [5:0]  q_d;
    logic [15:0] act [4];
    logic [15:0] expv [4];
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    localparam int          WV [4] = '{8, 4, 5, 6};
    localparam bit          GV [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam bit          XV [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
    localparam int          SV [4] = '{1, 3, 2, 1};
    localparam logic [15:0] MV [4] = '{16'h00B8, 16'h000C, 16'h0014, 16'h0030};
    localparam string       TAG [4] = '{"R3", "R4", "R5", "R5"};

    // {enable, load, mode, seed}
    localparam logic [18:0] VEC [12] = '{
        {3'b110, 16'h0001}, {3'b100, 16'h0000}, {3'b100, 16'h0000},
        {3'b000, 16'h0000}, {3'b000, 16'h0000}, {3'b011, 16'h0003},
        {3'b100, 16'h0000}, {3'b111, 16'h0006}, {3'b100, 16'h0000},
        {3'b010, 16'h0009}, {3'b100, 16'h0000}, {3'b100, 16'h0000}
    };

    always #4 clk = ~clk;

    lfsr_rng #(.W(8), .FORM(LFSR_FIB), .FB(FB_XOR), .STEPS(1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .adv_en_i(en), .seed_ld_i(ld),
        .seed_mode_i(md), .seed_i(seed[7:0]), .state_o(q_a));
    lfsr_rng #(.W(4), .FORM(LFSR_GAL), .FB(FB_XOR), .STEPS(3)) dut_b_i (
        .clk_i(clk), .rst_ni(rst_n), .adv_en_i(en), .seed_ld_i(ld),
        .seed_mode_i(md), .seed_i(seed[3:0]), .state_o(q_b));
    lfsr_rng #(.W(5), .FORM(LFSR_FIB), .FB(FB_XNOR), .STEPS(2),
               .HAS_SEED(1'b1), .SEED(5'h0B)) dut_c_i (
        .clk_i(clk), .rst_ni(rst_n), .adv_en_i(en), .seed_ld_i(ld),
        .seed_mode_i(md), .seed_i(seed[4:0]), .state_o(q_c));
    lfsr_rng #(.W(6), .FORM(LFSR_GAL), .FB(FB_XNOR), .STEPS(1)) dut_d_i (
        .clk_i(clk), .rst_ni(rst_n), .adv_en_i(en), .seed_ld_i(ld),
        .seed_mode_i(md), .seed_i(seed[5:0]), .state_o(q_d));

    assign act[0] = {8'h0, q_a};
    assign act[1] = {12'h0, q_b};
    assign act[2] = {11'h0, q_c};
    assign act[3] = {10'h0, q_d};

    function automatic logic [15:0] lim(input int w);
        return (16'h1 << w) - 16'h1;
    endfunction

    // One XOR update, written from R3/R4.
    function automatic logic [15:0] xor_step(input logic [15:0] s, input int k);
        logic [15:0] sh;
        logic        msb;
        sh  = (s << 1) & lim(WV[k]);
        msb = s[WV[k]-1];
        if (!GV[k]) return sh | {15'h0, ^(s & MV[k])};
        return (sh ^ (msb ? (((MV[k] << 1) | 16'h1) & lim(WV[k])) : 16'h0));
    endfunction

    // XNOR variant as the complement-conjugate of the XOR update (R5).
    function automatic logic [15:0] ref_n(input logic [15:0] s, input int k, input int n);
        logic [15:0] v = s & lim(WV[k]);
        for (int i = 0; i < n; i++) begin
            if (XV[k]) v = ~xor_step(~v & lim(WV[k]), k) & lim(WV[k]);
            else       v = xor_step(v, k);
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [15:0] a, input logic [15:0] e);
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, a, e);
        end
    endtask

    // Drive one cycle, update the model, check all four instances.
    task automatic apply(input logic e, input logic l, input logic m, input logic [15:0] sd,
                         input string rtag);
        en = e; ld = l; md = m; seed = sd;
        for (int k = 0; k < 4; k++) begin
            if (l)      expv[k] = m ? ref_n(sd, k, SV[k]) : (sd & lim(WV[k]));
            else if (e) expv[k] = ref_n(expv[k], k, SV[k]);
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < 4; k++) chk({rtag, " ", TAG[k]}, act[k], expv[k]);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev_a, prev_d;
        int          ret_a, ret_d, moved;
        #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset values
        chk("R1 fib-xor bit0", {15'h0, q_a[0]}, 16'h1);
        chk("R1 gal-xor bit0", {15'h0, q_b[0]}, 16'h1);
        chk("R1 build seed",   act[2], 16'h000B);
        chk("R1 gal-xnor bit0", {15'h0, q_d[0]}, 16'h0);
        rst_n = 1'b1;
        apply(1'b0, 1'b1, 1'b0, 16'h0005, "R7");

        // Table walk
        for (int r = 0; r < 12; r++) begin
            logic [18:0] v = VEC[r];
            string t;
            t = v[17] ? (v[16] ? "R8" : "R7") : (v[18] ? "R6" : "R2");
            apply(v[18], v[17], v[16], v[15:0], t);
        end

        // R9: full period on the 8-bit XOR and 6-bit XNOR instances
        apply(1'b0, 1'b1, 1'b0, 16'h0001, "R7");
        ret_a = 0; ret_d = 0; moved = 1;
        en = 1'b1; ld = 1'b0;
        for (int i = 1; i <= 255; i++) begin
            prev_a = act[0];
            prev_d = act[3];
            @(posedge clk);
            #1;
            if (act[0] == prev_a || act[3] == prev_d) moved = 0;
            if (ret_a == 0 && act[0] == 16'h0001) ret_a = i;
            if (ret_d == 0 && act[3] == 16'h0001) ret_d = i;
        end
        en = 1'b0;
        chk("R9 moves every step", moved[15:0], 16'h1);
        chk("R9 period width 8", ret_a[15:0], 16'd255);
        chk("R9 period width 6", ret_d[15:0], 16'd63);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule